// File: doc/BRIEF.md
# Centralized Scoreboard for Out-of-Order Issue Control

This block is the central bookkeeping for a small machine whose execution pipes can finish out of order. Each cycle it sees one decoded instruction (target execution unit, destination register, two source registers) and decides whether that instruction may be accepted. For every unit it already holds, it decides when the unit may fetch its operands and when it may put its result into the register file. It keeps one status entry per execution unit and one owner entry per architectural register. The datapath, fetch, decode and the pipes themselves are outside; a pipe reports the end of its work with a one-cycle done pulse.

An upstream decoder holds an instruction on the issue inputs until `iss_grant` is high. A refused instruction therefore blocks every later one, and issue stays in program order. Operand fetch and write-back are handed out by per-unit grant bits. There is no forwarding: a register written in one cycle can be read, at the earliest, in the next cycle.

Top module: `sb_scoreboard`

## Requirements
- R1: After reset no unit is busy and no register has an owner. `iss_grant`, `rd_grant` and `wb_grant` are all zero while `iss_valid` is low.
- R2: `iss_grant` is high in the same cycle as `iss_valid` exactly when the target unit is idle and the destination register has no owner. A granted instruction makes its unit busy from the next cycle. Units are numbered 1 to 4, and bit u-1 of each per-unit vector belongs to unit u.
- R3: An instruction whose destination register still has an owner is refused (WAW). It is refused in the owner's write-back cycle as well, and it is accepted in the cycle after that.
- R4: A busy unit gets one `rd_grant` pulse, at the earliest one cycle after issue, and only when neither of its sources is waiting on a producer.
- R5: A source that names a register owned by another unit waits until the cycle after that unit's `wb_grant`. There is no same-cycle forwarding (RAW).
- R6: An `exec_done` pulse counts only for a busy unit that has already read its operands. The unit's `wb_grant` comes at the earliest one cycle after the pulse, and `wb_reg` then carries its destination register.
- R7: A finished unit is denied write-back while another busy unit has not yet read a source equal to its destination and that source is marked ready (WAR). It is granted in the cycle after that reader's `rd_grant`.
- R8: At most one `wb_grant` bit is high per cycle. Among the units that may write, the lowest-numbered one wins, and the others wait for later cycles.
- R9: A unit cannot be issued to in its own write-back cycle. It can be issued to in the following cycle.
- R10: A target unit number of 0, or any number above 4, is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | A decoded instruction is offered |
| iss_unit | input | 3 | Target unit number, 1 to 4 |
| iss_dst | input | 3 | Destination register |
| iss_src_a | input | 3 | First source register |
| iss_src_b | input | 3 | Second source register |
| exec_done | input | 4 | Per-unit pulse: execution finished |
| iss_grant | output | 1 | Offered instruction accepted this cycle |
| rd_grant | output | 4 | Per-unit permission to read operands |
| wb_grant | output | 4 | Per-unit permission to write the result |
| wb_reg | output | 3 | Destination register of the granted write |

## Verification
The issue grant depends only on the current inputs and the registered state, so it is due in the cycle in which the instruction is offered. A read grant comes one or more cycles after issue. A write grant comes one cycle after the done pulse, or later if WAR or arbitration holds it back. A wake-up after a write shows as a read grant one cycle after that write. The bench applies inputs just after the falling edge, samples all outputs one nanosecond later in the same cycle, and compares them with a behavioural model that advances on each rising edge. The directed checks sit exactly on the cycles worked out from these latencies.

// File: rtl/sb_pkg.sv
package sb_pkg;
    parameter int SB_UNITS = 4;
    parameter int SB_REGS  = 8;
    localparam int UNIT_W  = $clog2(SB_UNITS + 1);
    localparam int REG_W   = $clog2(SB_REGS);

    typedef logic [UNIT_W-1:0] unit_t;
    typedef logic [REG_W-1:0]  reg_t;

    // per-unit status entry; unit number 0 means "no producer"
    typedef struct packed {
        logic  busy;
        logic  opnd_read;
        logic  exec_fin;
        reg_t  dst;
        reg_t  src_a;
        reg_t  src_b;
        unit_t prod_a;
        unit_t prod_b;
        logic  rdy_a;
        logic  rdy_b;
    } unit_status_t;

    typedef struct {
        unit_status_t unit [SB_UNITS];
        unit_t        owner [SB_REGS];
    } sb_state_t;
endpackage

// File: rtl/sb_war_check.sv
module sb_war_check
    import sb_pkg::*;
(
    input  logic [SB_UNITS-1:0] waiting,
    input  logic [SB_UNITS-1:0] rdy_a,
    input  logic [SB_UNITS-1:0] rdy_b,
    input  reg_t                src_a [SB_UNITS],
    input  reg_t                src_b [SB_UNITS],
    input  reg_t                dst   [SB_UNITS],
    output logic [SB_UNITS-1:0] block
);
    for (genvar w = 0; w < SB_UNITS; w++) begin : g_writer
        logic blk;
        always_comb begin
            blk = 1'b0;
            for (int r = 0; r < SB_UNITS; r++) begin
                if (r != w && waiting[r] &&
                    ((rdy_a[r] && src_a[r] == dst[w]) ||
                     (rdy_b[r] && src_b[r] == dst[w])))
                    blk = 1'b1;
            end
        end
        assign block[w] = blk;
    end
endmodule

// File: rtl/sb_wb_arbiter.sv
module sb_wb_arbiter #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    // lowest set bit wins
    assign gnt = req & (~req + N'(1));
endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard
    import sb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                iss_valid,
    input  logic [UNIT_W-1:0]   iss_unit,
    input  logic [REG_W-1:0]    iss_dst,
    input  logic [REG_W-1:0]    iss_src_a,
    input  logic [REG_W-1:0]    iss_src_b,
    input  logic [SB_UNITS-1:0] exec_done,
    output logic                iss_grant,
    output logic [SB_UNITS-1:0] rd_grant,
    output logic [SB_UNITS-1:0] wb_grant,
    output logic [REG_W-1:0]    wb_reg
);
    sb_state_t state_q, state_d;

    logic [SB_UNITS-1:0] war_block, wb_req;
    logic [SB_UNITS-1:0] waiting_v, rdy_a_v, rdy_b_v;
    reg_t                src_a_v [SB_UNITS];
    reg_t                src_b_v [SB_UNITS];
    reg_t                dst_v   [SB_UNITS];
    logic                unit_known, unit_free;
    unit_t               writer, pa, pb;

    always_comb begin : unpack_status
        for (int i = 0; i < SB_UNITS; i++) begin
            waiting_v[i] = state_q.unit[i].busy && !state_q.unit[i].opnd_read;
            rdy_a_v[i]   = state_q.unit[i].rdy_a;
            rdy_b_v[i]   = state_q.unit[i].rdy_b;
            src_a_v[i]   = state_q.unit[i].src_a;
            src_b_v[i]   = state_q.unit[i].src_b;
            dst_v[i]     = state_q.unit[i].dst;
        end
    end

    sb_war_check u_war (
        .waiting (waiting_v),
        .rdy_a   (rdy_a_v),
        .rdy_b   (rdy_b_v),
        .src_a   (src_a_v),
        .src_b   (src_b_v),
        .dst     (dst_v),
        .block   (war_block)
    );

    sb_wb_arbiter #(.N(SB_UNITS)) u_arb (
        .req (wb_req),
        .gnt (wb_grant)
    );

    always_comb begin : grant_gen
        unit_known = 1'b0;
        unit_free  = 1'b0;
        for (int i = 0; i < SB_UNITS; i++) begin
            rd_grant[i] = state_q.unit[i].busy && !state_q.unit[i].opnd_read &&
                          state_q.unit[i].rdy_a && state_q.unit[i].rdy_b;
            wb_req[i]   = state_q.unit[i].busy && state_q.unit[i].exec_fin &&
                          !war_block[i];
            if (iss_unit == unit_t'(i + 1)) begin
                unit_known = 1'b1;
                unit_free  = !state_q.unit[i].busy;
            end
        end
        iss_grant = iss_valid && unit_known && unit_free &&
                    (state_q.owner[iss_dst] == '0);
    end

    always_comb begin : next_state
        state_d = state_q;
        writer  = '0;
        wb_reg  = '0;
        for (int i = 0; i < SB_UNITS; i++) begin
            if (wb_grant[i]) begin
                writer = unit_t'(i + 1);
                wb_reg = state_q.unit[i].dst;
            end
        end
        // write-back: release writer, wake up its consumers
        if (writer != '0) begin
            state_d.owner[wb_reg] = '0;
            for (int i = 0; i < SB_UNITS; i++) begin
                if (wb_grant[i]) begin
                    state_d.unit[i] = '0;
                end else begin
                    if (state_q.unit[i].busy && state_q.unit[i].prod_a == writer) begin
                        state_d.unit[i].rdy_a  = 1'b1;
                        state_d.unit[i].prod_a = '0;
                    end
                    if (state_q.unit[i].busy && state_q.unit[i].prod_b == writer) begin
                        state_d.unit[i].rdy_b  = 1'b1;
                        state_d.unit[i].prod_b = '0;
                    end
                end
            end
        end
        for (int i = 0; i < SB_UNITS; i++) begin
            if (rd_grant[i])
                state_d.unit[i].opnd_read = 1'b1;
            if (exec_done[i] && state_q.unit[i].busy && state_q.unit[i].opnd_read &&
                !wb_grant[i])
                state_d.unit[i].exec_fin = 1'b1;
        end
        // issue: record the new entry
        pa = state_q.owner[iss_src_a];
        pb = state_q.owner[iss_src_b];
        if (writer != '0 && pa == writer) pa = '0;
        if (writer != '0 && pb == writer) pb = '0;
        if (iss_grant) begin
            state_d.owner[iss_dst] = iss_unit;
            for (int i = 0; i < SB_UNITS; i++) begin
                if (iss_unit == unit_t'(i + 1)) begin
                    state_d.unit[i].busy      = 1'b1;
                    state_d.unit[i].opnd_read = 1'b0;
                    state_d.unit[i].exec_fin  = 1'b0;
                    state_d.unit[i].dst       = iss_dst;
                    state_d.unit[i].src_a     = iss_src_a;
                    state_d.unit[i].src_b     = iss_src_b;
                    state_d.unit[i].prod_a    = pa;
                    state_d.unit[i].prod_b    = pb;
                    state_d.unit[i].rdy_a     = (pa == '0);
                    state_d.unit[i].rdy_b     = (pb == '0);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SB_UNITS; i++) state_q.unit[i] <= '0;
            for (int r = 0; r < SB_REGS; r++)  state_q.owner[r] <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/sb_scoreboard_chk.sv
module sb_scoreboard_chk
    import sb_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [UNIT_W-1:0]   iss_unit,
    input logic                iss_grant,
    input logic [SB_UNITS-1:0] rd_grant,
    input logic [SB_UNITS-1:0] wb_grant
);
    // R8
    wb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wb_grant));

    // R2
    busy_reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_grant |=> !(iss_grant && iss_unit == $past(iss_unit)));

    // R10
    bad_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_unit == '0 || int'(iss_unit) > SB_UNITS) |-> !iss_grant);

    for (genvar i = 0; i < SB_UNITS; i++) begin : g_unit
        // R4
        single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_grant[i] |=> !rd_grant[i]);
        // R6
        read_before_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_grant[i] |=> !wb_grant[i]);
        // R9
        no_issue_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wb_grant[i] |-> !(iss_grant && iss_unit == unit_t'(i + 1)));
    end
endmodule

bind sb_scoreboard sb_scoreboard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_unit  (iss_unit),
    .iss_grant (iss_grant),
    .rd_grant  (rd_grant),
    .wb_grant  (wb_grant)
);

// File: tb/sb_scoreboard_bench.sv
`timescale 1ns/1ps
module sb_scoreboard_bench;
    localparam int NU = 4;
    localparam int NR = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iss_valid = 1'b0;
    logic [2:0] iss_unit = '0, iss_dst = '0, iss_src_a = '0, iss_src_b = '0;
    logic [3:0] exec_done = '0;
    logic       iss_grant;
    logic [3:0] rd_grant, wb_grant;
    logic [2:0] wb_reg;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sb_scoreboard u_sb_scoreboard (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_unit(iss_unit),
        .iss_dst(iss_dst), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
        .exec_done(exec_done), .iss_grant(iss_grant), .rd_grant(rd_grant),
        .wb_grant(wb_grant), .wb_reg(wb_reg)
    );

    // behavioural reference model
    int m_busy[NU], m_rdd[NU], m_fin[NU], m_dst[NU], m_sa[NU], m_sb[NU];
    int m_qa[NU], m_qb[NU], m_ra[NU], m_rb[NU];
    int m_own[NR];
    int e_iss, e_rd, e_wb, e_wbreg, e_wr;

    task automatic model_reset();
        for (int i = 0; i < NU; i++) begin
            m_busy[i] = 0; m_rdd[i] = 0; m_fin[i] = 0; m_dst[i] = 0; m_sa[i] = 0;
            m_sb[i] = 0; m_qa[i] = 0; m_qb[i] = 0; m_ra[i] = 0; m_rb[i] = 0;
        end
        for (int r = 0; r < NR; r++) m_own[r] = 0;
    endtask

    task automatic model_eval();
        int u;
        u = int'(iss_unit);
        e_iss = (iss_valid && u >= 1 && u <= NU) ? 1 : 0;
        if (e_iss == 1 && (m_busy[u-1] != 0 || m_own[iss_dst] != 0)) e_iss = 0;
        e_rd = 0; e_wb = 0; e_wbreg = 0; e_wr = -1;
        for (int i = 0; i < NU; i++)
            if (m_busy[i] != 0 && m_rdd[i] == 0 && m_ra[i] != 0 && m_rb[i] != 0)
                e_rd |= (1 << i);
        for (int w = 0; w < NU; w++) begin
            bit blocked = 0;
            if (m_busy[w] == 0 || m_fin[w] == 0) continue;
            for (int r = 0; r < NU; r++)
                if (r != w && m_busy[r] != 0 && m_rdd[r] == 0 &&
                    ((m_ra[r] != 0 && m_sa[r] == m_dst[w]) ||
                     (m_rb[r] != 0 && m_sb[r] == m_dst[w])))
                    blocked = 1;
            if (!blocked && e_wr < 0) begin
                e_wr = w; e_wb = 1 << w; e_wbreg = m_dst[w];
            end
        end
    endtask

    task automatic model_step();
        int qa, qb, u;
        model_eval();
        qa = m_own[iss_src_a]; qb = m_own[iss_src_b];
        if (e_wr >= 0) begin
            if (qa == e_wr + 1) qa = 0;
            if (qb == e_wr + 1) qb = 0;
            m_own[m_dst[e_wr]] = 0;
            for (int i = 0; i < NU; i++) begin
                if (m_qa[i] == e_wr + 1) begin m_qa[i] = 0; m_ra[i] = 1; end
                if (m_qb[i] == e_wr + 1) begin m_qb[i] = 0; m_rb[i] = 1; end
            end
            m_busy[e_wr] = 0; m_rdd[e_wr] = 0; m_fin[e_wr] = 0;
        end
        for (int i = 0; i < NU; i++) begin
            if (e_rd[i]) m_rdd[i] = 1;
            if (exec_done[i] && m_busy[i] != 0 && m_rdd[i] != 0 && i != e_wr &&
                !e_rd[i])
                m_fin[i] = 1;
        end
        if (e_iss != 0) begin
            u = int'(iss_unit) - 1;
            m_busy[u] = 1; m_rdd[u] = 0; m_fin[u] = 0; m_dst[u] = iss_dst;
            m_sa[u] = iss_src_a; m_sb[u] = iss_src_b; m_qa[u] = qa; m_qb[u] = qb;
            m_ra[u] = (qa == 0); m_rb[u] = (qb == 0);
            m_own[iss_dst] = u + 1;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else model_step();
    end

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input bit v, input int u, input int d, input int a,
                       input int b, input int done);
        @(negedge clk);
        iss_valid = v; iss_unit = 3'(u); iss_dst = 3'(d);
        iss_src_a = 3'(a); iss_src_b = 3'(b); exec_done = 4'(done);
        #1;
        model_eval();
        chk(int'(iss_grant), e_iss, "R2 model issue grant");
        chk(int'(rd_grant), e_rd, "R4 model read grants");
        chk(int'(wb_grant), e_wb, "R8 model write grants");
        chk(int'(wb_reg), e_wbreg, "R8 model write register");
    endtask

    task automatic idle(input int done);
        cyc(0, 0, 0, 0, 0, done);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        idle(0);
        chk(int'(iss_grant), 0, "R1 issue after reset");
        chk(int'(rd_grant), 0, "R1 read after reset");
        chk(int'(wb_grant), 0, "R1 write after reset");

        // basic flow
        cyc(1, 1, 1, 2, 3, 0); chk(int'(iss_grant), 1, "R2 free unit issues");
        idle(0);               chk(int'(rd_grant), 1, "R4 read one cycle after issue");
        idle(1);               chk(int'(wb_grant), 0, "R6 no write in done cycle");
        idle(0);               chk(int'(wb_grant), 1, "R6 write after done");
                               chk(int'(wb_reg), 1, "R6 write register");
        idle(0);

        // R10 invalid unit numbers
        cyc(1, 0, 2, 0, 0, 0); chk(int'(iss_grant), 0, "R10 unit 0");
        cyc(1, 5, 2, 0, 0, 0); chk(int'(iss_grant), 0, "R10 unit 5");

        // R6 done on idle unit ignored
        idle(8);
        idle(0);               chk(int'(wb_grant), 0, "R6 done on idle unit");
        cyc(1, 4, 2, 0, 0, 0); chk(int'(iss_grant), 1, "R2 issue unit 4");
        idle(0);               chk(int'(rd_grant), 8, "R4 unit 4 read");
        idle(0);               chk(int'(wb_grant), 0, "R6 no write without done");
        idle(8);
        idle(0);               chk(int'(wb_grant), 8, "R6 unit 4 write");
        idle(0);

        // R3 WAW
        cyc(1, 1, 2, 0, 0, 0);
        cyc(1, 2, 2, 0, 0, 0); chk(int'(iss_grant), 0, "R3 owner pending");
        cyc(1, 2, 2, 0, 0, 1); chk(int'(iss_grant), 0, "R3 still pending");
        cyc(1, 2, 2, 0, 0, 0); chk(int'(wb_grant), 1, "R3 owner writes");
                               chk(int'(iss_grant), 0, "R3 refused in write cycle");
        cyc(1, 2, 2, 0, 0, 0); chk(int'(iss_grant), 1, "R3 accepted after write");
        idle(0); idle(2); idle(0); idle(0);

        // R5 RAW, no forwarding
        cyc(1, 1, 4, 2, 3, 0);
        cyc(1, 2, 5, 4, 2, 0); chk(int'(iss_grant), 1, "R5 consumer issues");
        idle(1);               chk(int'(rd_grant), 0, "R5 consumer waits");
        idle(0);               chk(int'(wb_grant), 1, "R5 producer writes");
                               chk(int'(rd_grant), 0, "R5 no forwarding");
        idle(0);               chk(int'(rd_grant), 2, "R5 read after write");
        idle(2); idle(0);      chk(int'(wb_reg), 5, "R5 consumer result");
        idle(0);

        // R7 WAR
        cyc(1, 1, 6, 0, 0, 0);
        cyc(1, 2, 5, 6, 3, 0);
        cyc(1, 3, 3, 0, 0, 0); chk(int'(iss_grant), 1, "R7 writer issues");
        idle(0);
        idle(4);
        idle(0);               chk(int'(wb_grant), 0, "R7 held by reader");
        idle(1);               chk(int'(wb_grant), 0, "R7 still held");
        idle(0);               chk(int'(wb_grant), 1, "R7 other unit writes");
        idle(0);               chk(int'(rd_grant), 2, "R7 reader reads");
                               chk(int'(wb_grant), 0, "R7 held in read cycle");
        idle(0);               chk(int'(wb_grant), 4, "R7 released");
                               chk(int'(wb_reg), 3, "R7 register");
        idle(2); idle(0); idle(0);

        // R8 priority, R9 release
        cyc(1, 1, 1, 0, 0, 0);
        cyc(1, 2, 2, 0, 0, 0);
        idle(0);
        idle(3);
        cyc(1, 1, 7, 0, 0, 0); chk(int'(wb_grant), 1, "R8 lowest unit first");
                               chk(int'(wb_reg), 1, "R8 register");
                               chk(int'(iss_grant), 0, "R9 no issue in release cycle");
        cyc(1, 1, 7, 0, 0, 0); chk(int'(wb_grant), 2, "R8 second unit next");
                               chk(int'(wb_reg), 2, "R8 second register");
                               chk(int'(iss_grant), 1, "R9 issue after release");
        idle(0); idle(1); idle(0); idle(0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule